// File: doc/BRIEF.md
# Nested-Loop Micro-op Sequencer

This block runs one matrix-multiply instruction. The instruction names a range of entries in a local micro-op memory and two loop counts. Each entry in that range holds three base indices: an accumulator index, a source (input buffer) index and a weight index. The block replays the range once for each pass of a two-level loop. For every micro-op it adds an inner-loop offset and an outer-loop offset to each base index, and sends the resulting index triple to a downstream multiply-accumulate datapath, one triple per clock.

Each address space has its own pair of stride factors, one for the inner loop and one for the outer loop. Index sums wrap modulo the depth of the buffer they address, and every depth is a power of two. The micro-op memory has one cycle of read latency. The address walk, the offset tracking and a two-stage index pipeline overlap, so a run of triples has no gaps. The instruction also carries a clear flag. It travels with every triple of that instruction, so the datapath overwrites the addressed accumulator entries instead of adding to them. A single-cycle done pulse marks the end of each instruction.

Top module: `uop_loop_sequencer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `out_valid`, `done` and `uop_rd_en` are 0.
- R2: Micro-op reads follow the order: outer count `i` from 0 up, then inner count `j` from 0 up, then address `k` from `cmd_uop_first` up to `cmd_uop_stop - 1`. One read is made per cycle.
- R3: A triple issued for loop position (i, j) from micro-op word `w` carries the following indices. The accumulator index is `w[5:0] + j*acc_in + i*acc_out` mod 64. The source index is `w[10:6] + j*src_in + i*src_out` mod 32. The weight index is `w[15:11] + j*wgt_in + i*wgt_out` mod 32.
- R4: An instruction issues exactly `outer*inner*(stop-first)` triples, in the order of R2, on consecutive cycles with no gap.
- R5: The first triple is valid two cycles after the first micro-op read request, which is itself the cycle after the accepting edge.
- R6: `cmd_uop_stop` is one bit wider than `cmd_uop_first`. A stop value equal to the micro-op depth (16) reads every address through 15.
- R7: If `first >= stop`, or the outer count is 0, or the inner count is 0, the instruction makes no reads and issues no triples. `done` then rises in the cycle after the accepting edge.
- R8: `done` is a one-cycle pulse. For a non-empty instruction it coincides with the last triple, and no triple is left outstanding.
- R9: `out_clear` equals the clear flag of the instruction that produced the triple, on every triple.
- R10: `cmd_ready` is 0 from the accepting edge until `done`, and is 1 again in the `done` cycle. An instruction presented while `cmd_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction present |
| cmd_ready | output | 1 | Block idle, instruction accepted on this edge if valid |
| cmd_clear | input | 1 | Overwrite instead of accumulate |
| cmd_uop_first | input | 4 | First micro-op address |
| cmd_uop_stop | input | 5 | Micro-op address one past the last |
| cmd_outer_cnt | input | 6 | Outer loop iterations |
| cmd_inner_cnt | input | 6 | Inner loop iterations |
| cmd_acc_step_out | input | 6 | Accumulator outer factor |
| cmd_acc_step_in | input | 6 | Accumulator inner factor |
| cmd_src_step_out | input | 5 | Source outer factor |
| cmd_src_step_in | input | 5 | Source inner factor |
| cmd_wgt_step_out | input | 5 | Weight outer factor |
| cmd_wgt_step_in | input | 5 | Weight inner factor |
| uop_rd_en | output | 1 | Micro-op memory read request |
| uop_rd_addr | output | 4 | Micro-op read address |
| uop_rd_data | input | 16 | Micro-op word, one cycle after the request |
| out_valid | output | 1 | Index triple valid |
| out_acc_idx | output | 6 | Accumulator index |
| out_src_idx | output | 5 | Source index |
| out_wgt_idx | output | 5 | Weight index |
| out_clear | output | 1 | Clear flag for this triple |
| done | output | 1 | Instruction finished |

## Verification
Most internal faults show at the ports within a few cycles. A wrong loop counter or pointer wrap appears at once as a wrong `uop_rd_addr`, two cycles before the bad triple leaves. A stale or wrongly stepped stride accumulator shows up as a wrong index on the first triple after the next inner or outer step. A lost or extra pipeline valid breaks the gap-free run or moves `done` off the last triple, in the same cycle. The reference model predicts every read address, every triple and the exact cycle of `done`, so each of these faults is caught in the cycle it reaches the ports.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  // An instruction with nothing to replay
  function automatic logic range_empty(input int unsigned first, input int unsigned stop,
                                       input int unsigned n_out, input int unsigned n_in);
    return (first >= stop) || (n_out == 0) || (n_in == 0);
  endfunction

endpackage

// File: rtl/useq_walker.sv
module useq_walker #(
  parameter int UW = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [UW-1:0] first,
  input  logic [UW:0]   stop,
  input  logic [CW-1:0] n_out,
  input  logic [CW-1:0] n_in,
  output logic          rd_en,
  output logic [UW-1:0] rd_addr,
  output logic          step_in,
  output logic          step_out,
  output logic          last
);
  import useq_pkg::*;

  localparam logic [UW-1:0] K_ONE  = 1;
  localparam logic [UW:0]   KW_ONE = 1;
  localparam logic [CW-1:0] C_ONE  = 1;
  localparam logic [CW:0]   CW_ONE = 1;

  walk_state_e   state_q, state_d;
  logic [UW-1:0] k_q, k_d, first_q;
  logic [UW:0]   stop_q;
  logic [CW-1:0] j_q, j_d, i_q, i_d, nout_q, nin_q;
  logic          run, k_wrap, j_wrap, i_end, walk_en;

  assign run     = (state_q == WALK_RUN);
  assign k_wrap  = (({1'b0, k_q} + KW_ONE) == stop_q);
  assign j_wrap  = k_wrap && (({1'b0, j_q} + CW_ONE) == {1'b0, nin_q});
  assign i_end   = (({1'b0, i_q} + CW_ONE) == {1'b0, nout_q});
  assign last    = run && j_wrap && i_end;
  assign step_in = run && k_wrap && !j_wrap;
  assign step_out = run && j_wrap;
  assign rd_en   = run;
  assign rd_addr = k_q;
  assign walk_en = start || run;

  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    j_d     = j_q;
    i_d     = i_q;
    if (start) begin
      state_d = WALK_RUN;
      k_d     = first;
      j_d     = '0;
      i_d     = '0;
    end else if (run) begin
      k_d = k_wrap ? first_q : (k_q + K_ONE);
      if (k_wrap) j_d = j_wrap ? '0 : (j_q + C_ONE);
      if (j_wrap) i_d = i_q + C_ONE;
      if (last) state_d = WALK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WALK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (walk_en) begin
      k_q <= k_d;
      j_q <= j_d;
      i_q <= i_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      first_q <= first;
      stop_q  <= stop;
      nout_q  <= n_out;
      nin_q   <= n_in;
    end
  end

endmodule

// File: rtl/useq_stride.sv
module useq_stride #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         start,
  input  logic         step_in,
  input  logic         step_out,
  input  logic [W-1:0] f_in,
  input  logic [W-1:0] f_out,
  output logic [W-1:0] off
);
  logic [W-1:0] fin_q, fout_q;
  logic [W-1:0] in_q, in_d, out_q, out_d;
  logic         acc_en;

  assign acc_en = start || step_in || step_out;
  assign off    = in_q + out_q;

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    if (start) begin
      in_d  = '0;
      out_d = '0;
    end else if (step_out) begin
      in_d  = '0;
      out_d = out_q + fout_q;
    end else if (step_in) begin
      in_d  = in_q + fin_q;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      fin_q  <= f_in;
      fout_q <= f_out;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/useq_pipe.sv
module useq_pipe #(
  parameter int AW = 6,
  parameter int SW = 5,
  parameter int WW = 5,
  localparam int UDW = AW + SW + WW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s0_valid,
  input  logic           s0_last,
  input  logic           s0_clear,
  input  logic [AW-1:0]  s0_acc_off,
  input  logic [SW-1:0]  s0_src_off,
  input  logic [WW-1:0]  s0_wgt_off,
  input  logic [UDW-1:0] uop_word,
  output logic           out_valid,
  output logic [AW-1:0]  out_acc,
  output logic [SW-1:0]  out_src,
  output logic [WW-1:0]  out_wgt,
  output logic           out_clear,
  output logic           s1_fin
);
  logic          s1_valid_q, s1_last_q, s1_clear_q;
  logic [AW-1:0] s1_acc_q, acc_sum;
  logic [SW-1:0] s1_src_q, src_sum;
  logic [WW-1:0] s1_wgt_q, wgt_sum;
  logic          ov_q;

  // Field positions of the micro-op word: accumulator low, source, weight high
  assign acc_sum = uop_word[AW-1:0]          + s1_acc_q;
  assign src_sum = uop_word[AW+SW-1:AW]      + s1_src_q;
  assign wgt_sum = uop_word[UDW-1:AW+SW]     + s1_wgt_q;
  assign s1_fin  = s1_valid_q && s1_last_q;
  assign out_valid = ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      ov_q       <= 1'b0;
    end else begin
      s1_valid_q <= s0_valid;
      ov_q       <= s1_valid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (s0_valid) begin
      s1_last_q  <= s0_last;
      s1_clear_q <= s0_clear;
      s1_acc_q   <= s0_acc_off;
      s1_src_q   <= s0_src_off;
      s1_wgt_q   <= s0_wgt_off;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) begin
      out_acc   <= acc_sum;
      out_src   <= src_sum;
      out_wgt   <= wgt_sum;
      out_clear <= s1_clear_q;
    end
  end

endmodule

// File: rtl/uop_loop_sequencer.sv
module uop_loop_sequencer #(
  parameter int UOP_DEPTH = 16,
  parameter int ACC_DEPTH = 64,
  parameter int SRC_DEPTH = 32,
  parameter int WGT_DEPTH = 32,
  parameter int ITER_W    = 6,
  localparam int UW  = $clog2(UOP_DEPTH),
  localparam int AW  = $clog2(ACC_DEPTH),
  localparam int SW  = $clog2(SRC_DEPTH),
  localparam int WW  = $clog2(WGT_DEPTH),
  localparam int UDW = AW + SW + WW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_clear,
  input  logic [UW-1:0]     cmd_uop_first,
  input  logic [UW:0]       cmd_uop_stop,
  input  logic [ITER_W-1:0] cmd_outer_cnt,
  input  logic [ITER_W-1:0] cmd_inner_cnt,
  input  logic [AW-1:0]     cmd_acc_step_out,
  input  logic [AW-1:0]     cmd_acc_step_in,
  input  logic [SW-1:0]     cmd_src_step_out,
  input  logic [SW-1:0]     cmd_src_step_in,
  input  logic [WW-1:0]     cmd_wgt_step_out,
  input  logic [WW-1:0]     cmd_wgt_step_in,
  output logic              uop_rd_en,
  output logic [UW-1:0]     uop_rd_addr,
  input  logic [UDW-1:0]    uop_rd_data,
  output logic              out_valid,
  output logic [AW-1:0]     out_acc_idx,
  output logic [SW-1:0]     out_src_idx,
  output logic [WW-1:0]     out_wgt_idx,
  output logic              out_clear,
  output logic              done
);
  logic          accept, empty, start, fin;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          clr_q;
  logic          step_in, step_out, last;
  logic [AW-1:0] acc_off;
  logic [SW-1:0] src_off;
  logic [WW-1:0] wgt_off;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign empty     = useq_pkg::range_empty(int'(cmd_uop_first), int'(cmd_uop_stop),
                                           int'(cmd_outer_cnt), int'(cmd_inner_cnt));
  assign start     = accept && !empty;
  assign done      = done_q;

  always_comb begin
    busy_d = busy_q;
    if (start)    busy_d = 1'b1;
    else if (fin) busy_d = 1'b0;
    done_d = fin || (accept && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) clr_q <= cmd_clear;
  end

  useq_walker #(.UW(UW), .CW(ITER_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .first    (cmd_uop_first),
    .stop     (cmd_uop_stop),
    .n_out    (cmd_outer_cnt),
    .n_in     (cmd_inner_cnt),
    .rd_en    (uop_rd_en),
    .rd_addr  (uop_rd_addr),
    .step_in  (step_in),
    .step_out (step_out),
    .last     (last)
  );

  useq_stride #(.W(AW)) u_acc_stride (
    .clk(clk), .start(start), .step_in(step_in), .step_out(step_out),
    .f_in(cmd_acc_step_in), .f_out(cmd_acc_step_out), .off(acc_off)
  );

  useq_stride #(.W(SW)) u_src_stride (
    .clk(clk), .start(start), .step_in(step_in), .step_out(step_out),
    .f_in(cmd_src_step_in), .f_out(cmd_src_step_out), .off(src_off)
  );

  useq_stride #(.W(WW)) u_wgt_stride (
    .clk(clk), .start(start), .step_in(step_in), .step_out(step_out),
    .f_in(cmd_wgt_step_in), .f_out(cmd_wgt_step_out), .off(wgt_off)
  );

  useq_pipe #(.AW(AW), .SW(SW), .WW(WW)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .s0_valid   (uop_rd_en),
    .s0_last    (last),
    .s0_clear   (clr_q),
    .s0_acc_off (acc_off),
    .s0_src_off (src_off),
    .s0_wgt_off (wgt_off),
    .uop_word   (uop_rd_data),
    .out_valid  (out_valid),
    .out_acc    (out_acc_idx),
    .out_src    (out_src_idx),
    .out_wgt    (out_wgt_idx),
    .out_clear  (out_clear),
    .s1_fin     (fin)
  );

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int UW = 4,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [UW-1:0] cmd_uop_first,
  input logic [UW:0]   cmd_uop_stop,
  input logic [CW-1:0] cmd_outer_cnt,
  input logic [CW-1:0] cmd_inner_cnt,
  input logic          uop_rd_en,
  input logic          out_valid,
  input logic          out_clear,
  input logic          done
);

  // R5
  read_to_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_rd_en |-> ##2 out_valid);

  // R4
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> out_valid);

  // R7
  empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (({1'b0, cmd_uop_first} >= cmd_uop_stop) ||
     (cmd_outer_cnt == '0) || (cmd_inner_cnt == '0))) |=> (done && !uop_rd_en));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_rd_en || out_valid) && !done) |-> !cmd_ready);

  // R8
  lone_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !out_valid) |-> $past(cmd_valid && cmd_ready));

  // R9
  clear_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_clear == $past(out_clear)));

endmodule

bind uop_loop_sequencer useq_checker #(.UW(UW), .CW(ITER_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_uop_first (cmd_uop_first),
  .cmd_uop_stop  (cmd_uop_stop),
  .cmd_outer_cnt (cmd_outer_cnt),
  .cmd_inner_cnt (cmd_inner_cnt),
  .uop_rd_en     (uop_rd_en),
  .out_valid     (out_valid),
  .out_clear     (out_clear),
  .done          (done)
);

// File: tb/uop_loop_sequencer_bench.sv
module uop_loop_sequencer_bench;
  localparam int UOP_N = 16, ACC_N = 64, SRC_N = 32, WGT_N = 32;
  localparam int UW = 4, AW = 6, SW = 5, WW = 5, CW = 6;
  localparam int UDW = AW + SW + WW;
  localparam int EW  = 1 + UDW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0, cmd_ready, cmd_clear = 1'b0;
  logic [UW-1:0]  cmd_uop_first = '0;
  logic [UW:0]    cmd_uop_stop = '0;
  logic [CW-1:0]  cmd_outer_cnt = '0, cmd_inner_cnt = '0;
  logic [AW-1:0]  cmd_acc_step_out = '0, cmd_acc_step_in = '0;
  logic [SW-1:0]  cmd_src_step_out = '0, cmd_src_step_in = '0;
  logic [WW-1:0]  cmd_wgt_step_out = '0, cmd_wgt_step_in = '0;
  logic           uop_rd_en;
  logic [UW-1:0]  uop_rd_addr;
  logic [UDW-1:0] uop_rd_data;
  logic           out_valid, out_clear, done;
  logic [AW-1:0]  out_acc_idx;
  logic [SW-1:0]  out_src_idx;
  logic [WW-1:0]  out_wgt_idx;

  uop_loop_sequencer u_uop_loop_sequencer (.*);

  always #5 clk = ~clk;

  // Micro-op memory model with one cycle of read latency
  logic [UDW-1:0] umem [UOP_N];
  logic [UDW-1:0] mem_q;
  initial begin
    for (int a = 0; a < UOP_N; a++)
      umem[a] = {WW'((a * 3 + 11) % WGT_N), SW'((a * 5 + 1) % SRC_N), AW'((a * 7 + 3) % ACC_N)};
  end
  always @(posedge clk) if (uop_rd_en) mem_q <= umem[uop_rd_addr];
  assign uop_rd_data = mem_q;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, errors = 0;
  logic [EW-1:0] exp_q[$];
  int  addr_q[$];
  logic [EW-1:0] e;
  int  acc_cyc, n_seen, n_exp;
  bit  in_flight = 0, done_seen = 0, is_empty = 0, prev_valid = 0;

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the reference queues
  always @(negedge clk) begin
    if (rst_n && in_flight) begin
      if (uop_rd_en) begin
        if (addr_q.size() == 0) chk("R7 unexpected micro-op read", 1, 0);
        else chk("R2 read address", int'(uop_rd_addr), addr_q.pop_front());
      end
      if (cyc >= acc_cyc && !done) chk("R10 ready low while busy", int'(cmd_ready), 0);
      if (out_valid) begin
        n_seen++;
        if (n_seen == 1) chk("R5 first triple cycle", cyc, acc_cyc + 2);
        else chk("R4 no gap in run", int'(prev_valid), 1);
        if (exp_q.size() == 0) chk("R4 extra triple", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R3 accumulator index", int'(out_acc_idx), int'(e[AW-1:0]));
          chk("R3 source index", int'(out_src_idx), int'(e[AW+SW-1:AW]));
          chk("R3 weight index", int'(out_wgt_idx), int'(e[UDW-1:AW+SW]));
          chk("R9 clear flag", int'(out_clear), int'(e[EW-1]));
        end
      end
      if (done) begin
        chk("R8 done with last triple", int'(out_valid), is_empty ? 0 : 1);
        chk("R8 nothing outstanding", exp_q.size(), 0);
        if (is_empty) chk("R7 done one cycle after accept", cyc, acc_cyc);
        in_flight = 0;
        done_seen = 1;
      end
      prev_valid = out_valid;
    end else if (rst_n && (out_valid || done)) begin
      chk("R8 activity while idle", 1, 0);
    end
  end

  task automatic run_cmd(input bit clr, input int first, input int stop, input int no, input int ni,
                         input int afo, input int afi, input int sfo, input int sfi,
                         input int wfo, input int wfi, input int hold);
    @(negedge clk);
    chk("R10 ready when idle", int'(cmd_ready), 1);
    is_empty = (first >= stop) || (no == 0) || (ni == 0);
    n_exp = 0;
    if (!is_empty) begin
      for (int i = 0; i < no; i++)
        for (int j = 0; j < ni; j++)
          for (int k = first; k < stop; k++) begin
            int a, s, w;
            a = ((k * 7 + 3) % ACC_N + j * afi + i * afo) % ACC_N;
            s = ((k * 5 + 1) % SRC_N + j * sfi + i * sfo) % SRC_N;
            w = ((k * 3 + 11) % WGT_N + j * wfi + i * wfo) % WGT_N;
            exp_q.push_back({clr, WW'(w), SW'(s), AW'(a)});
            addr_q.push_back(k);
            n_exp++;
          end
    end
    n_seen = 0; prev_valid = 0; done_seen = 0;
    acc_cyc = cyc + 1;
    in_flight = 1;
    cmd_clear        = clr;
    cmd_uop_first    = UW'(first);
    cmd_uop_stop     = (UW+1)'(stop);
    cmd_outer_cnt    = CW'(no);
    cmd_inner_cnt    = CW'(ni);
    cmd_acc_step_out = AW'(afo);
    cmd_acc_step_in  = AW'(afi);
    cmd_src_step_out = SW'(sfo);
    cmd_src_step_in  = SW'(sfi);
    cmd_wgt_step_out = WW'(wfo);
    cmd_wgt_step_in  = WW'(wfi);
    cmd_valid = 1'b1;
    @(negedge clk);
    if (hold > 0) begin
      // R10: a different instruction held while busy must be ignored
      cmd_clear = ~clr;
      cmd_uop_first = 4'd0;
      cmd_acc_step_in = 6'd9;
      cmd_wgt_step_out = 5'd7;
      repeat (hold) @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    chk("R4 triple count", n_seen, n_exp);
    chk("R2 all reads made", addr_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", int'(cmd_ready), 1);
    chk("R1 no triple after reset", int'(out_valid), 0);
    chk("R1 no done after reset", int'(done), 0);
    chk("R1 no read after reset", int'(uop_rd_en), 0);

    // R2 R3 R4: basic two-level walk
    run_cmd(0, 2, 5, 2, 3, 4, 1, 3, 2, 1, 5, 0);
    // R3 wrap of every index space
    run_cmd(0, 0, 4, 3, 3, 50, 40, 30, 29, 31, 17, 0);
    // R6 stop equals depth
    run_cmd(0, 13, 16, 2, 2, 1, 2, 3, 4, 5, 6, 0);
    run_cmd(0, 0, 16, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R8 single triple: done on the first and only one
    run_cmd(0, 7, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 empty forms
    run_cmd(0, 5, 5, 2, 2, 1, 1, 1, 1, 1, 1, 0);
    run_cmd(0, 9, 3, 2, 2, 1, 1, 1, 1, 1, 1, 0);
    run_cmd(0, 0, 4, 0, 2, 1, 1, 1, 1, 1, 1, 0);
    run_cmd(1, 0, 4, 2, 0, 1, 1, 1, 1, 1, 1, 0);
    // R9 R10 clear flag, ignored instruction while busy
    run_cmd(1, 1, 4, 2, 3, 2, 3, 4, 5, 6, 7, 4);
    run_cmd(0, 3, 6, 2, 3, 1, 1, 1, 1, 1, 1, 3);
    // Inner count 1 with several outer passes, and the reverse
    run_cmd(1, 4, 6, 4, 1, 13, 61, 7, 9, 11, 3, 0);
    run_cmd(0, 10, 12, 1, 5, 5, 63, 2, 31, 4, 30, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule